// File: doc/BRIEF.md
# Share-Weighted Round-Robin Slave Arbiter

This block sits in front of one shared slave port, typically an external memory, and decides which of several masters may drive it. Each master has its own share: the number of consecutive accepted transfers it is guaranteed once it wins. While the winner keeps requesting and has share left, the grant stays with it. When the share is used up, or the winner stops requesting, the grant passes to the next requesting master in fixed round-robin order. The search starts just after the last holder.

Each master port is a valid/ready pair. A master raises `m_valid` and must hold it until it sees `m_ready`. `m_ready` is high only for the granted master, and only in a cycle where the slave's `s_ready` is high. A low `m_ready` is the wait signal seen by losing or stalled masters. On the slave side, `s_valid` and `s_owner` tell the slave path which master's request is presented. `s_ready` is the slave's back-pressure. A transfer completes in a cycle where both `s_valid` and `s_ready` are high.

The default setup has three masters: index 0 is the processor instruction fetch port, index 1 is the processor data port, and index 2 is a block-move engine. Their shares are 1, 1 and 8. A 32-transfer block from the engine therefore spans at least four separate tenures whenever the processor ports also compete.

Top module: `share_arbiter`

## Requirements
- R1: While reset is asserted with no requests, every `m_ready` bit and `s_valid` are 0. The first grant after reset searches from master index 0 upward.
- R2: At most one `m_ready` bit is high. It is high only for the master named by `s_owner`, only when that master's `m_valid` is high and only when `s_ready` is high.
- R3: A transfer counts against the holder's share only in a cycle where its `m_valid` and `s_ready` are both high. Stalled cycles consume nothing.
- R4: A holder that keeps requesting keeps the grant until it has completed exactly its share of transfers.
- R5: When the share is exhausted, the grant goes to the first requesting master found by scanning indices holder+1, holder+2, and so on, with wrap-around. If only the holder is requesting, it wins again with a fresh share.
- R6: If the holder drops `m_valid` before its share is used, the grant moves to the next requester in round-robin order in that same cycle.
- R7: While a presented request is stalled (`s_valid` high, `s_ready` low), the grant does not change in the following cycle as long as that master still requests.
- R8: The default shares are 1, 1 and 8 for indices 0, 1 and 2. With all three requesting continuously and no stalls, master 2 gets runs of exactly 8 transfers, separated by one transfer each from masters 0 and 1.
- R9: `s_valid` is high exactly when at least one `m_valid` is high. `s_owner` then carries the index of the granted master.
- R10: With no requests, `s_valid` is 0 and no `m_ready` is high. The round-robin position is kept, so the next search starts after the last holder.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_valid | input | N_MST | Per-master request (valid), held until accepted |
| m_ready | output | N_MST | Per-master accept; low means wait |
| s_valid | output | 1 | A granted request is presented to the slave |
| s_owner | output | $clog2(N_MST) | Index of the granted master |
| s_ready | input | 1 | Slave can accept the presented transfer this cycle |

## Verification
The bench targets the share boundary. A counter that is off by one would give the block-move engine 7 or 9 transfers instead of 8, and the rotation sequence would diverge from the model at once. Stall windows with all masters requesting check that back-pressure neither consumes share nor moves the grant. A design that counted stalled cycles would hand the grant over early. A design that re-arbitrated during a stall would let a different master's ready through. Early release and the sole-requester case are driven explicitly: a stale share count would either hold the grant for an absent master or refuse the lone requester a fresh tenure. A long random mix of requests and back-pressure is then compared against the behavioural model on every cycle.

// File: rtl/sa_pkg.sv
package sa_pkg;
  // width of one share field; holds values 1..32
  localparam int SA_SHW = 6;
  typedef logic [SA_SHW-1:0] sa_share_t;
endpackage

// File: rtl/sa_rr_pick.sv
module sa_rr_pick #(
  parameter int N_MST = 3,
  localparam int IW = $clog2(N_MST)
) (
  input  logic [N_MST-1:0] req,
  input  logic [IW-1:0]    last,
  output logic [IW-1:0]    pick,
  output logic             found
);
  // scan last+1, last+2, ... wrapping; the last index itself is tried last
  always_comb begin
    pick  = last;
    found = 1'b0;
    for (int k = 1; k <= N_MST; k++) begin
      int idx;
      idx = (int'(last) + k) % N_MST;
      if (!found && req[idx]) begin
        pick  = IW'(idx);
        found = 1'b1;
      end
    end
  end

  always_comb begin
    assert (found == (|req)) else $error("AST_PICK_FOUND"); // R5
  end
endmodule

// File: rtl/sa_tenure.sv
module sa_tenure
  import sa_pkg::*;
#(
  parameter int N_MST = 3,
  parameter logic [N_MST*SA_SHW-1:0] SHARES = {6'd8, 6'd1, 6'd1},
  localparam int IW = $clog2(N_MST)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_MST-1:0] req,
  input  logic             s_ready,
  input  logic [IW-1:0]    rr_pick,
  input  logic             rr_found,
  output logic [IW-1:0]    owner,
  output logic [IW-1:0]    gnt,
  output logic             gnt_vld
);
  logic      holding;
  sa_share_t used, used_nxt, share_cur;
  logic      keep, acc;

  always_comb begin
    share_cur = SHARES[int'(owner)*SA_SHW +: SA_SHW];
    keep      = holding && req[owner] && (used < share_cur);
    gnt       = keep ? owner : rr_pick;
    gnt_vld   = keep || rr_found;
    acc       = gnt_vld && req[gnt] && s_ready;
    used_nxt  = (keep ? used : '0) + SA_SHW'(acc);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner   <= IW'(N_MST-1);
      used    <= '0;
      holding <= 1'b0;
    end else if (gnt_vld) begin
      owner   <= gnt;
      used    <= used_nxt;
      holding <= 1'b1;
    end else begin
      holding <= 1'b0;
    end
  end

  AST_SHARE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    holding |-> (used <= share_cur)) else $error("AST_SHARE_CAP"); // R4

  AST_NO_COUNT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (keep && !s_ready) |=> (used == $past(used))) else $error("AST_NO_COUNT_STALL"); // R3
endmodule

// File: rtl/share_arbiter.sv
module share_arbiter
  import sa_pkg::*;
#(
  parameter int N_MST = 3,
  parameter logic [N_MST*SA_SHW-1:0] SHARES = {6'd8, 6'd1, 6'd1},
  localparam int IW = $clog2(N_MST)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_MST-1:0] m_valid,
  output logic [N_MST-1:0] m_ready,
  output logic             s_valid,
  output logic [IW-1:0]    s_owner,
  input  logic             s_ready
);
  logic [IW-1:0] owner, rr_pick, gnt;
  logic          rr_found, gnt_vld;

  sa_rr_pick #(.N_MST(N_MST)) u_pick (
    .req(m_valid), .last(owner), .pick(rr_pick), .found(rr_found)
  );

  sa_tenure #(.N_MST(N_MST), .SHARES(SHARES)) u_ten (
    .clk(clk), .rst_n(rst_n), .req(m_valid), .s_ready(s_ready),
    .rr_pick(rr_pick), .rr_found(rr_found),
    .owner(owner), .gnt(gnt), .gnt_vld(gnt_vld)
  );

  assign s_valid = gnt_vld;
  assign s_owner = gnt;

  for (genvar i = 0; i < N_MST; i++) begin : g_rdy
    assign m_ready[i] = gnt_vld && (gnt == IW'(i)) && s_ready;
  end

  AST_ONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(m_ready)) else $error("AST_ONE_READY"); // R2

  AST_READY_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    ((m_ready & ~m_valid) == '0)) else $error("AST_READY_HAS_VALID"); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid == '0) |-> (!s_valid && m_ready == '0)) else $error("AST_IDLE_QUIET"); // R10

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && !s_ready) |=> (!m_valid[$past(s_owner)] || s_owner == $past(s_owner)))
    else $error("AST_STALL_HOLD"); // R7
endmodule

// File: tb/sim_share_arbiter.sv
module sim_share_arbiter;
  localparam int CLK_NS = 10;
  localparam int N = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] m_valid = '0;
  logic [2:0] m_ready;
  logic       s_valid;
  logic [1:0] s_owner;
  logic       s_ready = 1'b0;

  int n_cmp = 0, n_bad = 0;

  // behavioural reference state
  int sh [N] = '{1, 1, 8};
  int md_owner = N - 1, md_used = 0;
  bit md_hold = 0;
  int dma_run = 0, dma_max = 0, dma_min = 99;

  share_arbiter u0 (.clk(clk), .rst_n(rst_n), .m_valid(m_valid), .m_ready(m_ready),
                    .s_valid(s_valid), .s_owner(s_owner), .s_ready(s_ready));

  always #(CLK_NS/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic [2:0] v, input logic r, input string tag);
    int g; bit fresh, any;
    logic [2:0] erdy;
    @(negedge clk);
    m_valid = v; s_ready = r;
    #1;
    any = (v != 0); fresh = 1; g = md_owner;
    if (md_hold && v[md_owner] && md_used < sh[md_owner]) fresh = 0;
    else begin
      for (int k = 1; k <= N; k++) begin
        int idx = (md_owner + k) % N;
        if (v[idx]) begin g = idx; break; end
      end
    end
    erdy = '0;
    if (any && r) erdy[g] = 1'b1;
    chk(s_valid == any, {tag, " R9 s_valid"}, s_valid, any);
    if (any) chk(s_owner == g, {tag, " R5 s_owner"}, s_owner, g);
    chk(m_ready == erdy, {tag, " R2 m_ready"}, m_ready, erdy);
    // DMA run tracking (R8)
    if (m_ready[2]) dma_run++;
    else if (m_ready != 0 && dma_run > 0) begin
      if (dma_run > dma_max) dma_max = dma_run;
      if (dma_run < dma_min) dma_min = dma_run;
      dma_run = 0;
    end
    if (any) begin
      if (fresh) md_used = 0;
      md_owner = g;
      md_used += (r ? 1 : 0);
      md_hold = 1;
    end else md_hold = 0;
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R1: idle outputs during reset
    repeat (3) @(negedge clk);
    #1;
    chk(m_ready == 0, "R1 reset m_ready", m_ready, 0);
    chk(s_valid == 0, "R1 reset s_valid", s_valid, 0);
    @(negedge clk); rst_n = 1'b1;

    // R1/R4/R5/R8: everyone requests, no back-pressure
    dma_run = 0;
    for (int c = 0; c < 40; c++) step(3'b111, 1'b1, "all");
    chk(dma_max == 8, "R8 dma run max", dma_max, 8);
    chk(dma_min == 8, "R8 dma run min", dma_min, 8);

    // R3/R7: stalls while all request
    for (int c = 0; c < 12; c++) step(3'b111, (c % 3) == 0, "stall");

    // R6: DMA drops early; only DMA requests -> fresh share (R5)
    for (int c = 0; c < 10; c++) step(3'b100, 1'b1, "dma_solo");
    step(3'b011, 1'b1, "drop");
    step(3'b111, 1'b1, "drop");
    for (int c = 0; c < 3; c++) step(3'b111, 1'b1, "dma_hold");
    step(3'b011, 1'b1, "R6 early_release");
    step(3'b110, 1'b1, "R6 after");

    // R10: idle keeps position
    for (int c = 0; c < 4; c++) step(3'b000, 1'b1, "R10 idle");
    step(3'b111, 1'b1, "R10 resume");

    // mixed random traffic
    for (int c = 0; c < 400; c++) step(3'($urandom), 1'($urandom % 4 != 0), "rand");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule